// File: doc/BRIEF.md
# Multi-Watchdog Reset Controller

This block watches three processors at once. Each processor has its own watchdog counter, and that processor's software must restart the counter with a kick strobe before it runs out. If any one of the three counters runs out, or software raises a reset command strobe, the block pulls its active-low chip reset output low. The output stays low for a fixed number of input-clock cycles and then lets go. All three processors share this one reset, whichever counter caused it. While the reset is low, the block also raises a control that puts the general I/O pins into high impedance.

The block runs on the raw input clock. Inside, it makes a divide-by-two enable that stands for the symmetric system clock, and the watchdogs count those enable ticks. Because the timeout is a fixed number of ticks, its length in time changes inversely with the clock frequency. The default of 2^22 ticks gives about 839 ms at a 10 MHz input and about 210 ms at 40 MHz. A sticky cause register records what started the most recent reset. It can be read after the pulse ends, and only power-on clears it.

All strobes are plain one-cycle control inputs. The block has no data stream, so there is no valid/ready handshake at its edge.

Top module: `wdog_rst_ctrl`

## Requirements
- R1: When `sw_rst_i` is high in a cycle while the reset output is released, `rst_n_o` is low from the next cycle on.
- R2: Once it is asserted, `rst_n_o` stays low for exactly `PULSE_CYCLES` (default 256) input-clock cycles and then returns high.
- R3: A watchdog that gets no kick expires on the `WDOG_TICKS`-th enable tick counted from zero, and `rst_n_o` goes low in the cycle after that tick.
- R4: A kick on `kick_i[i]` clears only watchdog i on the next edge. The other watchdogs keep counting.
- R5: A kick that arrives in the same cycle as its watchdog's expiring tick is ignored, and the reset is still taken.
- R6: `io_hiz_o` is high in exactly the cycles in which `rst_n_o` is low.
- R7: `cause_o` bits 0 to 2 flag watchdogs 0 to 2, and bit 3 flags the software command. When a reset starts, `cause_o` is loaded with every trigger that was active in that cycle. It then holds that value until the next reset starts.
- R8: Watchdog expiries and software commands that arrive while the pulse is active neither extend the pulse nor change `cause_o`.
- R9: All watchdogs are held at zero from the triggering edge until the pulse ends. After release, each one needs a full `WDOG_TICKS` ticks before it can expire again.
- R10: The system-clock enable is low in the first cycle after `por_n` is released and then alternates every cycle. So with no kicks at all, the first reset starts `2*WDOG_TICKS` cycles after `por_n` is released.
- R11: While `por_n` is low, `rst_n_o` is high, `io_hiz_o` is low and `cause_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Raw input clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| kick_i | input | NUM_CPU | Per-processor watchdog restart strobes |
| sw_rst_i | input | 1 | Software reset command strobe |
| rst_n_o | output | 1 | Chip reset drive, active low |
| io_hiz_o | output | 1 | High-impedance control for general I/O, active high |
| cause_o | output | NUM_CPU+1 | Sticky cause of the last reset: {software, watchdog[NUM_CPU-1:0]} |

## Verification
Each input takes effect one edge later. A software command or an expiring tick makes `rst_n_o` and `io_hiz_o` change after the edge that samples it, and `cause_o` is loaded on that same edge. Release comes `PULSE_CYCLES` edges after the edge that triggered the reset. The bench drives inputs at the falling edge and advances a reference model by one rising edge. It compares at the following falling edge, so every expected value lines up with the cycle in which the registered output actually changes. Directed cases count cycles from power-on release to the first expiry and count the low cycles of each pulse. They also place a kick exactly on an expiring tick.

// File: rtl/wdog_rst_pkg.sv
package wdog_rst_pkg;
  typedef enum logic {
    PH_RUN  = 1'b0,
    PH_HOLD = 1'b1
  } pulse_phase_e;

  function automatic int unsigned width_for(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen (
  input  logic clk,
  input  logic por_n,
  output logic tick_o
);
  logic half_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) half_q <= 1'b0;
    else        half_q <= ~half_q;
  end

  assign tick_o = half_q;
endmodule

// File: rtl/wdog_chan.sv
module wdog_chan #(
  parameter int unsigned WDOG_TICKS = 32'd4194304
) (
  input  logic clk,
  input  logic por_n,
  input  logic tick_i,
  input  logic run_i,
  input  logic clr_i,
  input  logic kick_i,
  output logic expire_o
);
  localparam int unsigned CW = wdog_rst_pkg::width_for(WDOG_TICKS);
  localparam logic [CW-1:0] LAST = CW'(WDOG_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last  = (cnt_q == LAST);
  assign expire_o = run_i & tick_i & at_last;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (kick_i) begin
      cnt_q <= '0;
    end else if (tick_i && !at_last) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/wdog_pulse_gen.sv
module wdog_pulse_gen #(
  parameter int unsigned NUM_CPU      = 3,
  parameter int unsigned PULSE_CYCLES = 256
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic [NUM_CPU-1:0] wd_exp_i,
  input  logic               sw_i,
  output logic               hold_o,
  output logic               trig_o,
  output logic [NUM_CPU:0]   cause_o
);
  import wdog_rst_pkg::*;

  localparam int unsigned PW = width_for(PULSE_CYCLES);
  localparam logic [PW-1:0] PLAST = PW'(PULSE_CYCLES - 1);

  pulse_phase_e    phase_q;
  logic [PW-1:0]   len_q;
  logic [NUM_CPU:0] cause_q;

  assign trig_o = (phase_q == PH_RUN) & (sw_i | (|wd_exp_i));
  assign hold_o = (phase_q == PH_HOLD);
  assign cause_o = cause_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      phase_q <= PH_RUN;
      len_q   <= '0;
      cause_q <= '0;
    end else begin
      case (phase_q)
        PH_RUN: begin
          if (trig_o) begin
            phase_q <= PH_HOLD;
            len_q   <= '0;
            cause_q <= {sw_i, wd_exp_i};
          end
        end
        PH_HOLD: begin
          if (len_q == PLAST) begin
            phase_q <= PH_RUN;
            len_q   <= '0;
          end else begin
            len_q <= len_q + PW'(1);
          end
        end
        default: phase_q <= PH_RUN;
      endcase
    end
  end
endmodule

// File: rtl/wdog_rst_ctrl.sv
module wdog_rst_ctrl #(
  parameter int unsigned NUM_CPU      = 3,
  parameter int unsigned WDOG_TICKS   = 32'd4194304,
  parameter int unsigned PULSE_CYCLES = 256
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic [NUM_CPU-1:0] kick_i,
  input  logic               sw_rst_i,
  output logic               rst_n_o,
  output logic               io_hiz_o,
  output logic [NUM_CPU:0]   cause_o
);
  logic               tick;
  logic               hold;
  logic               trig;
  logic               clr_all;
  logic [NUM_CPU-1:0] wd_exp;

  wdog_tick_gen u_tick (
    .clk    (clk),
    .por_n  (por_n),
    .tick_o (tick)
  );

  assign clr_all = hold | trig;

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_chan
    wdog_chan #(.WDOG_TICKS(WDOG_TICKS)) u_chan (
      .clk      (clk),
      .por_n    (por_n),
      .tick_i   (tick),
      .run_i    (~hold),
      .clr_i    (clr_all),
      .kick_i   (kick_i[g]),
      .expire_o (wd_exp[g])
    );
  end

  wdog_pulse_gen #(
    .NUM_CPU      (NUM_CPU),
    .PULSE_CYCLES (PULSE_CYCLES)
  ) u_pulse (
    .clk      (clk),
    .por_n    (por_n),
    .wd_exp_i (wd_exp),
    .sw_i     (sw_rst_i),
    .hold_o   (hold),
    .trig_o   (trig),
    .cause_o  (cause_o)
  );

  assign rst_n_o  = ~hold;
  assign io_hiz_o = hold;
endmodule

// File: rtl/wdog_rst_checker.sv
module wdog_rst_checker #(
  parameter int unsigned NUM_CPU      = 3,
  parameter int unsigned PULSE_CYCLES = 256
) (
  input logic               clk,
  input logic               por_n,
  input logic               sw_rst_i,
  input logic               rst_n_o,
  input logic               io_hiz_o,
  input logic [NUM_CPU:0]   cause_o
);
  logic [31:0] low_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        low_cnt <= '0;
    else if (!rst_n_o) low_cnt <= low_cnt + 32'd1;
    else               low_cnt <= '0;
  end

  // R1
  a_r1_sw_asserts: assert property (@(posedge clk) disable iff (!por_n)
    (sw_rst_i && rst_n_o) |=> !rst_n_o);

  // R2, R8
  a_r2_pulse_holds: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_n_o && low_cnt < 32'(PULSE_CYCLES - 1)) |=> !rst_n_o);

  a_r2_pulse_ends: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_n_o && low_cnt == 32'(PULSE_CYCLES - 1)) |=> rst_n_o);

  // R6
  a_r6_hiz_matches: assert property (@(posedge clk) disable iff (!por_n)
    io_hiz_o == !rst_n_o);

  // R7
  a_r7_cause_sticky: assert property (@(posedge clk) disable iff (!por_n)
    !$fell(rst_n_o) |-> $stable(cause_o));

  a_r7_cause_set: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_n_o) |-> (cause_o != '0));

  // R11
  always @(posedge clk) begin
    if (!por_n) begin
      a_r11_por_state: assert (rst_n_o && !io_hiz_o && cause_o == '0);
    end
  end
endmodule

bind wdog_rst_ctrl wdog_rst_checker #(
  .NUM_CPU      (NUM_CPU),
  .PULSE_CYCLES (PULSE_CYCLES)
) u_chk (
  .clk      (clk),
  .por_n    (por_n),
  .sw_rst_i (sw_rst_i),
  .rst_n_o  (rst_n_o),
  .io_hiz_o (io_hiz_o),
  .cause_o  (cause_o)
);

// File: tb/tb_wdog_rst_ctrl.sv
module tb_wdog_rst_ctrl;
  localparam int T = 40;
  localparam int P = 256;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic [2:0] kick = '0;
  logic       sw = 1'b0;
  logic       rst_n;
  logic       hiz;
  logic [3:0] cause;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_rst_ctrl #(.NUM_CPU(3), .WDOG_TICKS(T), .PULSE_CYCLES(P)) dut (
    .clk(clk), .por_n(por_n), .kick_i(kick), .sw_rst_i(sw),
    .rst_n_o(rst_n), .io_hiz_o(hiz), .cause_o(cause)
  );

  // reference model state (value after the latest rising edge)
  bit       m_ce;
  int       m_cnt [3];
  bit       m_act;
  int       m_len;
  bit [3:0] m_cause;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic bit exp_now(input int i);
    return !m_act && m_ce && (m_cnt[i] == T - 1);
  endfunction

  task automatic model_reset();
    m_ce = 0; m_act = 0; m_len = 0; m_cause = '0;
    for (int i = 0; i < 3; i++) m_cnt[i] = 0;
  endtask

  task automatic compare();
    chk(rst_n == !m_act, "R2/R3/R1 rst_n_o", rst_n, !m_act);
    chk(hiz == m_act,    "R6 io_hiz_o", hiz, m_act);
    chk(cause == m_cause, "R7/R8 cause_o", cause, m_cause);
  endtask

  // called at a falling edge: drive, advance model, sample at next falling edge
  task automatic step(input logic [2:0] k, input logic s);
    bit [2:0] e;
    bit trig;
    kick = k; sw = s;
    for (int i = 0; i < 3; i++) e[i] = exp_now(i);
    trig = !m_act && (s || (|e));
    if (m_act) begin
      if (m_len == P - 1) begin m_act = 0; m_len = 0; end
      else m_len++;
      for (int i = 0; i < 3; i++) m_cnt[i] = 0;
    end else if (trig) begin
      m_act = 1; m_len = 0; m_cause = {s, e};
      for (int i = 0; i < 3; i++) m_cnt[i] = 0;
    end else begin
      for (int i = 0; i < 3; i++)
        if (k[i]) m_cnt[i] = 0;
        else if (m_ce && m_cnt[i] < T - 1) m_cnt[i]++;
    end
    m_ce = !m_ce;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic wait_release();
    int n = 0;
    while (!rst_n && n < 2 * P) begin step(3'b000, 1'b0); n++; end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int n;
    int low;
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    // R11: power-on state
    chk(rst_n == 1'b1, "R11 rst_n_o in por", rst_n, 1);
    chk(hiz == 1'b0,   "R11 io_hiz_o in por", hiz, 0);
    chk(cause == 4'b0, "R11 cause_o in por", cause, 0);
    por_n = 1'b1;

    // R10, R3: no kicks, first reset 2*T cycles after release, all three fire
    n = 0;
    while (rst_n && n < 4 * T) begin step(3'b000, 1'b0); n++; end
    chk(n == 2 * T, "R10 cycles to first expiry", n, 2 * T);
    chk(cause == 4'b0111, "R3/R7 cause all watchdogs", cause, 7);

    // R2, R8: pulse length with software and no kicks during it
    low = 1;
    while (!rst_n && low < 2 * P) begin step(3'b000, (low == 10) ? 1'b1 : 1'b0); if (!rst_n) low++; end
    chk(low == P, "R2/R8 pulse length", low, P);
    chk(cause == 4'b0111, "R8 cause unchanged by pulse-time command", cause, 7);

    // R4, R9: starve watchdog 0 only, full timeout after release
    n = 0;
    while (rst_n && n < 4 * T) begin step(3'b110, 1'b0); n++; end
    chk(n == 2 * T || n == 2 * T - 1, "R9 full timeout after release", n, 2 * T);
    chk(cause == 4'b0001, "R4 only watchdog 0 cause", cause, 1);
    wait_release();

    // R5: kick exactly on expiring tick is ignored
    n = 0;
    while (!exp_now(2) && n < 4 * T) begin step(3'b011, 1'b0); n++; end
    step(3'b111, 1'b0);
    chk(rst_n == 1'b0, "R5 kick on expiry ignored", rst_n, 0);
    chk(cause == 4'b0100, "R5 cause watchdog 2", cause, 4);
    wait_release();

    // R1: software command
    step(3'b111, 1'b0);
    step(3'b111, 1'b1);
    chk(rst_n == 1'b0, "R1 software reset", rst_n, 0);
    chk(cause == 4'b1000, "R1/R7 cause software", cause, 8);
    wait_release();

    // random mix
    for (int i = 0; i < 20000; i++) begin
      logic [2:0] k;
      for (int j = 0; j < 3; j++) k[j] = ($urandom % 100) < 3;
      step(k, ($urandom % 1000) < 2);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule